// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm

This block keeps the seconds, minutes and hours of a real-time clock and moves them forward by one second on each accepted update tick. At run time the host chooses whether the registers hold BCD digits or plain binary numbers, and whether hours run on a 24-hour dial or on a 12-hour dial with a PM flag in bit 7. Three alarm registers are compared with the advanced time. When all three fields agree, a one-cycle alarm pulse is raised. An alarm byte whose two top bits are both set matches any value.

The host loads both the time registers and the alarm registers through a simple write port, one byte per cycle. A hold input stops the clock from advancing so that a multi-byte load stays consistent. When the hours wrap past midnight, the block emits a one-cycle day-rollover pulse for a downstream calendar stage.

Top module: `tod_alarm_clock`

## Requirements
- R1: After a synchronous reset the seconds, minutes and hours outputs read 0x00, all three alarm registers hold 0x00, and both pulse outputs are low.
- R2: The write port decodes `wr_addr` as follows: 0 = seconds, 1 = seconds alarm, 2 = minutes, 3 = minutes alarm, 4 = hours, 5 = hours alarm. A written time value appears on its output in the cycle after the write.
- R3: With `bin_mode`=0 (BCD), an advance steps the low nibble from 9 to 0 and increments the high nibble. Seconds and minutes wrap from 0x59 to 0x00, and each wrap carries into the next field.
- R4: With `bin_mode`=1 (binary), seconds and minutes count 0 to 59 (0x3B) and then wrap to 0 with a carry. Hours count in binary as well.
- R5: With `mode_24h`=1, hours count 0 to 23. The advance from 23:59:59 to 00:00:00 raises `day_roll`.
- R6: With `mode_24h`=0, bit 7 of the hours byte is PM and bits 6:0 run 12, 1, 2, ..., 11. PM toggles on the 11 to 12 step. `day_roll` fires only on the step from 11:59:59 PM to 12:00:00 AM.
- R7: While `set_hold`=1, `tick` does not change the time.
- R8: A write to a time register (offset 0, 2 or 4) in the same cycle as a tick loads the written value and cancels that tick for every field.
- R9: `alarm_pulse` is high for exactly the cycle in which the advanced time first appears, provided all three fields equal their alarm bytes.
- R10: An alarm byte with bits 7:6 equal to 2'b11 matches every value of its field.
- R11: `alarm_pulse` and `day_roll` are high only in the cycle after an accepted tick.
- R12: Writes to offsets 6 and 7 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-second update strobe |
| set_hold | input | 1 | Blocks advancement while high |
| bin_mode | input | 1 | 1 = binary encoding, 0 = BCD |
| mode_24h | input | 1 | 1 = 24-hour dial, 0 = 12-hour dial with PM in bit 7 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register offset |
| wr_data | input | 8 | Write data |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours (bit 7 = PM on the 12-hour dial) |
| alarm_pulse | output | 1 | One-cycle alarm match |
| day_roll | output | 1 | One-cycle midnight rollover |

## Verification
The assertions check on every cycle that:
- hold freezes the time;
- a seconds write beats a coincident tick;
- both pulses follow only an accepted tick;
- a day rollover lands on zero minutes and seconds;
- writes to unused offsets leave the time unchanged.

The carry arithmetic can only be shown by the bench's scenarios. These cover BCD nibble carries, binary wrap at 59, the 12-hour sequence with its PM toggle, and the exact midnight step in each dial. The scenarios also cover alarm matching with and without wildcard bytes.

// File: rtl/tod_pkg.sv
// Shared constants for the time-of-day counter.
// Assumes byte-wide registers and a 3-bit register offset.
package tod_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        OFS_SEC    = 3'd0,
        OFS_SEC_AL = 3'd1,
        OFS_MIN    = 3'd2,
        OFS_MIN_AL = 3'd3,
        OFS_HR     = 3'd4,
        OFS_HR_AL  = 3'd5
    } tod_ofs_e;

    localparam logic [1:0] ALARM_ANY = 2'b11;
endpackage

// File: rtl/tod_field_inc.sv
// Combinational one-step incrementer for a 0..MAX_VAL field.
// In BCD mode the low nibble carries after 9. In either mode the
// field wraps to zero after MAX_VAL and raises wrap_o.
// Assumes the input is a legal value in the selected encoding.
module tod_field_inc #(
    parameter int W       = 8,
    parameter int MAX_VAL = 59
) (
    input  logic [W-1:0] val_i,
    input  logic         bin_i,
    output logic [W-1:0] nxt_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] LIM_BIN = W'(MAX_VAL);
    localparam logic [W-1:0] LIM_BCD = W'(((MAX_VAL / 10) << 4) | (MAX_VAL % 10));

    logic [W-1:0] lim;

    // Select the wrap limit and form the next value.
    always_comb begin
        lim    = bin_i ? LIM_BIN : LIM_BCD;
        wrap_o = 1'b0;
        if (val_i == lim) begin
            nxt_o  = '0;
            wrap_o = 1'b1;
        end else if (!bin_i && val_i[3:0] == 4'd9) begin
            nxt_o = {val_i[W-1:4] + 1'b1, 4'h0};
        end else begin
            nxt_o = val_i + 1'b1;
        end
    end
endmodule

// File: rtl/tod_hour_inc.sv
// Next-hour logic for both dials.
// On the 24-hour dial it reuses the generic incrementer with a limit of 23.
// On the 12-hour dial it steps 12,1..11, toggles PM (bit 7) on 11->12,
// and flags the day boundary at 11 PM -> 12 AM.
// Assumes legal hour values in the selected encoding.
module tod_hour_inc (
    input  logic [7:0] hr_i,
    input  logic       bin_i,
    input  logic       h24_i,
    output logic [7:0] hr_o,
    output logic       day_o
);
    logic [7:0] h24_nxt;
    logic       h24_wrap;
    logic [6:0] v;
    logic [6:0] twelve;
    logic [6:0] eleven;
    logic       pm;

    tod_field_inc #(.W(8), .MAX_VAL(23)) u_h24 (
        .val_i (hr_i),
        .bin_i (bin_i),
        .nxt_o (h24_nxt),
        .wrap_o(h24_wrap)
    );

    // Choose the dial and compute the next hour with its day flag.
    always_comb begin
        v      = hr_i[6:0];
        pm     = hr_i[7];
        twelve = bin_i ? 7'd12 : 7'h12;
        eleven = bin_i ? 7'd11 : 7'h11;
        day_o  = 1'b0;
        if (h24_i) begin
            hr_o  = h24_nxt;
            day_o = h24_wrap;
        end else if (v == twelve) begin
            hr_o = {pm, 7'd1};
        end else if (v == eleven) begin
            hr_o  = {~pm, twelve};
            day_o = pm;
        end else if (!bin_i && v[3:0] == 4'd9) begin
            hr_o = {pm, v[6:4] + 3'd1, 4'h0};
        end else begin
            hr_o = {pm, v + 7'd1};
        end
    end
endmodule

// File: rtl/tod_alarm_cmp.sv
// Compares NF time fields against their alarm bytes.
// A field matches when it is equal to its alarm byte or when the
// alarm byte's top two bits are both set (wildcard).
module tod_alarm_cmp
    import tod_pkg::*;
#(
    parameter int NF = 3
) (
    input  logic [NF-1:0][DATA_W-1:0] time_i,
    input  logic [NF-1:0][DATA_W-1:0] alarm_i,
    output logic                      hit_o
);
    logic [NF-1:0] field_ok;

    for (genvar f = 0; f < NF; f++) begin : g_field
        // Per-field match: wildcard or exact equality.
        assign field_ok[f] = (alarm_i[f][DATA_W-1:DATA_W-2] == ALARM_ANY) ||
                             (alarm_i[f] == time_i[f]);
    end

    assign hit_o = &field_ok;
endmodule

// File: rtl/tod_alarm_clock.sv
// Time-of-day register bank with per-tick advance, host write port,
// alarm matching and a midnight rollover pulse.
// Assumes the host writes legal values for the selected encoding/dial.
// A write to any time register cancels a coincident tick.
module tod_alarm_clock
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              set_hold,
    input  logic              bin_mode,
    input  logic              mode_24h,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] sec_o,
    output logic [DATA_W-1:0] min_o,
    output logic [DATA_W-1:0] hour_o,
    output logic              alarm_pulse,
    output logic              day_roll
);
    localparam int NF = 3;

    logic [DATA_W-1:0] sec_q, min_q, hr_q;
    logic [DATA_W-1:0] sec_al_q, min_al_q, hr_al_q;
    logic [DATA_W-1:0] sec_inc, min_inc, hr_inc;
    logic [DATA_W-1:0] sec_n, min_n, hr_n;
    logic              sec_wrap, min_wrap, hr_day;
    logic              time_wr, adv, hit, roll_n;

    tod_field_inc #(.W(DATA_W), .MAX_VAL(59)) u_sec (
        .val_i(sec_q), .bin_i(bin_mode), .nxt_o(sec_inc), .wrap_o(sec_wrap)
    );
    tod_field_inc #(.W(DATA_W), .MAX_VAL(59)) u_min (
        .val_i(min_q), .bin_i(bin_mode), .nxt_o(min_inc), .wrap_o(min_wrap)
    );
    tod_hour_inc u_hr (
        .hr_i(hr_q), .bin_i(bin_mode), .h24_i(mode_24h), .hr_o(hr_inc), .day_o(hr_day)
    );

    // Ripple the carries across the fields to form the advanced time.
    always_comb begin
        sec_n  = sec_inc;
        min_n  = sec_wrap ? min_inc : min_q;
        hr_n   = (sec_wrap && min_wrap) ? hr_inc : hr_q;
        roll_n = sec_wrap && min_wrap && hr_day;
    end

    tod_alarm_cmp #(.NF(NF)) u_cmp (
        .time_i ({hr_n, min_n, sec_n}),
        .alarm_i({hr_al_q, min_al_q, sec_al_q}),
        .hit_o  (hit)
    );

    // Decide whether this cycle advances: a time write or hold blocks it.
    always_comb begin
        time_wr = wr_en && (wr_addr == OFS_SEC || wr_addr == OFS_MIN || wr_addr == OFS_HR);
        adv     = tick && !set_hold && !time_wr;
    end

    // Register bank: reset, advance, then host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q       <= '0;
            min_q       <= '0;
            hr_q        <= '0;
            sec_al_q    <= '0;
            min_al_q    <= '0;
            hr_al_q     <= '0;
            alarm_pulse <= 1'b0;
            day_roll    <= 1'b0;
        end else begin
            alarm_pulse <= adv && hit;
            day_roll    <= adv && roll_n;
            if (adv) begin
                sec_q <= sec_n;
                min_q <= min_n;
                hr_q  <= hr_n;
            end
            if (wr_en) begin
                case (wr_addr)
                    OFS_SEC:    sec_q    <= wr_data;
                    OFS_SEC_AL: sec_al_q <= wr_data;
                    OFS_MIN:    min_q    <= wr_data;
                    OFS_MIN_AL: min_al_q <= wr_data;
                    OFS_HR:     hr_q     <= wr_data;
                    OFS_HR_AL:  hr_al_q  <= wr_data;
                    default:    ;
                endcase
            end
        end
    end

    assign sec_o  = sec_q;
    assign min_o  = min_q;
    assign hour_o = hr_q;

    // R7: hold with no write keeps the time still.
    a_r7_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (set_hold && !wr_en) |=> (sec_o == $past(sec_o) && min_o == $past(min_o) && hour_o == $past(hour_o)));

    // R8: a seconds write wins over a coincident tick.
    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_SEC) |=> (sec_o == $past(wr_data)));

    // R11: pulses only follow an accepted tick.
    a_r11_pulse_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_pulse || day_roll) |-> $past(tick && !set_hold));

    // R5: a rollover lands on zero minutes and seconds.
    a_r5_roll_at_midnight: assert property (@(posedge clk) disable iff (!rst_n)
        day_roll |-> (sec_o == '0 && min_o == '0));

    // R12: writes to unused offsets without a tick leave the time unchanged.
    a_r12_unused_offsets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > OFS_HR_AL && !tick) |=> $stable({sec_o, min_o, hour_o}));
endmodule

// File: tb/tod_alarm_clock_tb_top.sv
module tod_alarm_clock_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, set_hold = 1'b0, bin_mode = 1'b0, mode_24h = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] sec_o, min_o, hour_o;
    logic       alarm_pulse, day_roll;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    tod_alarm_clock dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .set_hold(set_hold),
        .bin_mode(bin_mode), .mode_24h(mode_24h), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o),
        .hour_o(hour_o), .alarm_pulse(alarm_pulse), .day_roll(day_roll)
    );

    typedef struct packed {
        logic       bin;
        logic       h24;
        logic [7:0] s, m, h;
        logic [7:0] es, em, eh;
        logic       roll;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 8'h09, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 1'b0}, // R3 nibble carry
        '{1'b0, 1'b1, 8'h59, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 1'b0}, // R3 seconds wrap
        '{1'b0, 1'b1, 8'h59, 8'h59, 8'h00, 8'h00, 8'h00, 8'h01, 1'b0}, // R3 minute wrap
        '{1'b0, 1'b1, 8'h59, 8'h59, 8'h09, 8'h00, 8'h00, 8'h10, 1'b0}, // R5 hour nibble
        '{1'b0, 1'b1, 8'h59, 8'h59, 8'h23, 8'h00, 8'h00, 8'h00, 1'b1}, // R5 midnight
        '{1'b1, 1'b1, 8'h3B, 8'h3B, 8'h17, 8'h00, 8'h00, 8'h00, 1'b1}, // R4 binary midnight
        '{1'b1, 1'b1, 8'h09, 8'h00, 8'h00, 8'h0A, 8'h00, 8'h00, 1'b0}, // R4 no nibble carry
        '{1'b0, 1'b0, 8'h59, 8'h59, 8'h11, 8'h00, 8'h00, 8'h92, 1'b0}, // R6 11AM->12PM
        '{1'b0, 1'b0, 8'h59, 8'h59, 8'h91, 8'h00, 8'h00, 8'h12, 1'b1}, // R6 11PM->12AM
        '{1'b0, 1'b0, 8'h59, 8'h59, 8'h12, 8'h00, 8'h00, 8'h01, 1'b0}, // R6 12->1
        '{1'b0, 1'b0, 8'h59, 8'h59, 8'h89, 8'h00, 8'h00, 8'h90, 1'b0}, // R6 9PM->10PM
        '{1'b1, 1'b0, 8'h3B, 8'h3B, 8'h8B, 8'h00, 8'h00, 8'h0C, 1'b1}, // R6 binary 11PM
        '{1'b1, 1'b0, 8'h3B, 8'h3B, 8'h0C, 8'h00, 8'h00, 8'h01, 1'b0}  // R6 binary 12->1
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic with_tick = 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; tick = with_tick;
        @(posedge clk); #1;
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
        tick = 1'b1;
        @(posedge clk); #1;
        tick = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 sec", sec_o, 8'h00);
        chk("R1 min", min_o, 8'h00);
        chk("R1 hour", hour_o, 8'h00);
        chk("R1 pulses", {6'd0, alarm_pulse, day_roll}, 8'h00);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bin_mode = VECS[i].bin; mode_24h = VECS[i].h24;
            wr(3'd0, VECS[i].s);
            wr(3'd2, VECS[i].m);
            wr(3'd4, VECS[i].h);
            chk("R2 hour readback", hour_o, VECS[i].h);
            step();
            chk("R3-table sec", sec_o, VECS[i].es);
            chk("R3-table min", min_o, VECS[i].em);
            chk("R5/R6 hour", hour_o, VECS[i].eh);
            chk("R5/R6 roll", {7'd0, day_roll}, {7'd0, VECS[i].roll});
        end

        // R7 hold blocks the tick
        @(negedge clk); bin_mode = 1'b0; mode_24h = 1'b1;
        wr(3'd0, 8'h20); wr(3'd2, 8'h00); wr(3'd4, 8'h00);
        @(negedge clk); set_hold = 1'b1;
        step();
        chk("R7 sec held", sec_o, 8'h20);
        @(negedge clk); set_hold = 1'b0;

        // R8 write beats coincident tick
        wr(3'd0, 8'h30, 1'b1);
        chk("R8 sec written", sec_o, 8'h30);
        chk("R8 min unchanged", min_o, 8'h00);

        // R12 unused offsets
        wr(3'd6, 8'h45);
        wr(3'd7, 8'h12);
        chk("R12 sec", sec_o, 8'h30);
        chk("R12 min", min_o, 8'h00);
        chk("R12 hour", hour_o, 8'h00);

        // R9 exact alarm match
        wr(3'd1, 8'h10); wr(3'd3, 8'h00); wr(3'd5, 8'h00);
        wr(3'd0, 8'h09);
        chk("R11 no pulse w/o tick", {7'd0, alarm_pulse}, 8'h00);
        step();
        chk("R9 alarm hit", {7'd0, alarm_pulse}, 8'h01);
        step();
        chk("R9 alarm miss", {7'd0, alarm_pulse}, 8'h00);
        @(posedge clk); #1;
        chk("R11 pulse gone", {7'd0, alarm_pulse}, 8'h00);

        // R10 wildcard seconds and minutes
        wr(3'd1, 8'hC0); wr(3'd3, 8'hC5);
        step();
        chk("R10 wildcard hit", {7'd0, alarm_pulse}, 8'h01);
        wr(3'd5, 8'h05);
        step();
        chk("R10 hour mismatch", {7'd0, alarm_pulse}, 8'h00);
        wr(3'd5, 8'hFF);
        step();
        chk("R10 all wildcard", {7'd0, alarm_pulse}, 8'h01);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule